// File: doc/BRIEF.md
# Timed Page Load Program Sequencer

This block runs the page-programming phase of a one-time-programmable memory once the command decoder has accepted a program command. The system writes words as chip-enable low pulses with output-enable held high. Each word's address is taken when chip-enable falls and its data when chip-enable rises. The words go into a 64-word page buffer, in any order. Loading has no fixed word count. It closes when chip-enable stays idle too long after the last completed load, or when a load arrives after the continuity window has run out.

After loading closes, the block counts a modelled programming interval in microsecond ticks. It then streams the finished page out, one word per handshake, and reports the result to the status register as a one-cycle done pulse. The block raises a fail pulse alongside done, and sends no page data, in two cases: a load names a different page from the first load, or the test fail-injection input is high when the interval ends.

The page stream is valid/ready. `out_valid` rises only after the interval has ended. While `out_ready` is low, the block holds `out_valid`, `out_addr` and `out_data` unchanged. A word counts as transferred on a clock edge where both are high, and the next word follows on the next cycle. The status and control pins are plain levels or pulses.

Top module: `pgload_seq`

## Requirements
- R1: During and right after reset, `busy`, `done`, `fail` and `out_valid` are all 0.
- R2: A `start` pulse while idle with `inhibit` low makes `busy` 1 from the next cycle on. A `start` pulse while `inhibit` is high leaves `busy` at 0.
- R3: A load is one chip-enable low pulse with output-enable high at the falling edge. The address is sampled at the falling edge and the data at the rising edge. A chip-enable pulse whose falling edge sees output-enable low writes nothing.
- R4: Address bits [19:6] are the page and bits [5:0] the word offset. Streamed word k carries `out_addr` = {page, k[5:0]}. When no word was loaded, the page is 0.
- R5: Loads may come in any order. A later load to the same offset replaces the earlier data.
- R6: An offset that was not loaded since the accepted `start` streams out as 16'hFFFF.
- R7: A load whose page differs from the first load's page ends the sequence at once. `done` and `fail` pulse together for one cycle, `busy` drops in that same cycle, and no word is streamed.
- R8: If LOAD_END_US (100) ticks pass with chip-enable high after the last completed load (or after `start`, if nothing was loaded), loading closes. `out_valid` rises LOAD_END_US + PROG_US (120) ticks after that last rising edge.
- R9: A load whose falling edge comes more than GAP_US (30) ticks after the previous completed load is not stored. Loading closes at that edge, and `out_valid` rises PROG_US ticks later.
- R10: `busy` stays 1 throughout the programming interval. A successful sequence ends with a one-cycle `done` pulse, `fail` 0, and `busy` dropping in the same cycle.
- R11: Exactly 64 words stream out, offsets in ascending order. While `out_valid` is 1 and `out_ready` is 0, the valid flag, address and data stay unchanged.
- R12: If `fail_inject` is 1 when the interval ends, `done` and `fail` pulse together and no word is streamed.
- R13: A `start` pulse while busy is ignored. It does not clear the page that has been loaded so far.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Accepted program command, one-cycle pulse |
| inhibit | input | 1 | Program inhibit from the status register (failure not yet cleared) |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| fail_inject | input | 1 | Test input that forces a programming failure |
| ce_n | input | 1 | Sampled chip-enable, active low |
| oe_n | input | 1 | Sampled output-enable, active low |
| addr | input | 20 | Word address |
| data | input | 16 | Write data |
| busy | output | 1 | Sequence in progress (status bit 7 reads its inverse) |
| done | output | 1 | One-cycle pulse when the sequence ends |
| fail | output | 1 | One-cycle pulse with `done` on failure |
| out_valid | output | 1 | Programmed word available |
| out_ready | input | 1 | Consumer takes the word |
| out_addr | output | 20 | Address of the streamed word |
| out_data | output | 16 | Programmed data |

## Verification
Most state errors in this block show up in the streamed page, within one sequence. A wrongly latched offset or page, a lost overwrite, or a buffer that was not preset shows as a wrong word or address within 64 handshakes of `out_valid` rising. A wrong idle or interval count shows as `out_valid` rising at a different tick count after the last load, so the bench measures that distance exactly. A mishandled mismatch, a late load or fail injection shows as a `done`/`fail` pair in the wrong cycle, or as data streamed when none should be.

// File: rtl/pgload_pkg.sv
package pgload_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_PROG  = 2'd2,
    ST_DRAIN = 2'd3
  } pg_state_e;

  function automatic int pg_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pgload_edge.sv
// Chip-enable edge tracking: opens a load on the falling edge (output-enable
// high), closes it on the rising edge while the load is pending.
module pgload_edge #(
  parameter int AW = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic          accept,
  output logic          open_pulse,
  output logic          close_pulse,
  output logic          pending,
  output logic [AW-1:0] cap_addr
);
  logic ce_q;
  logic fall, rise;

  assign fall        = ce_q & ~ce_n;
  assign rise        = ~ce_q & ce_n;
  assign open_pulse  = arm & fall & oe_n;
  assign close_pulse = arm & pending & rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ce_q     <= 1'b1;
      pending  <= 1'b0;
      cap_addr <= '0;
    end else begin
      ce_q <= ce_n;
      if (!arm || rise) pending <= 1'b0;
      else if (open_pulse && accept) pending <= 1'b1;
      if (open_pulse) cap_addr <= addr;
    end
  end

  // R3: a load stays pending only while chip-enable is held low
  p_pending_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && ce_n && arm) |=> !pending);
endmodule

// File: rtl/pgload_timer.sv
// Saturating microsecond counter with synchronous clear.
module pgload_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          tick,
  output logic [CW-1:0] cnt
);
  localparam logic [CW-1:0] MAXV = '1;

  always_ff @(posedge clk) begin
    if (!rst_n)                          cnt <= '0;
    else if (clr)                        cnt <= '0;
    else if (en && tick && cnt != MAXV)  cnt <= cnt + 1'b1;
  end

  // R8: the counter never wraps back to zero on its own
  p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && cnt == MAXV) |=> (cnt == MAXV || $past(clr) || clr));
endmodule

// File: rtl/pgload_buf.sv
// Page buffer: preset to all ones on clear, single write port, read by offset.
module pgload_buf #(
  parameter int WORDS = 64,
  parameter int DW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(WORDS)-1:0] raddr,
  output logic [DW-1:0]            rdata
);
  localparam int OW = $clog2(WORDS);

  logic [WORDS-1:0]         wsel;
  logic [WORDS-1:0][DW-1:0] mem;

  for (genvar i = 0; i < WORDS; i++) begin : g_sel
    assign wsel[i] = we && (waddr == OW'(i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      mem <= '1;
    end else begin
      for (int i = 0; i < WORDS; i++)
        if (wsel[i]) mem[i] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  // R5: a write lands in the addressed word on the next cycle
  p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/pgload_seq.sv
module pgload_seq #(
  parameter int AW          = 20,
  parameter int DW          = 16,
  parameter int PAGE_WORDS  = 64,
  parameter int LOAD_END_US = 100,
  parameter int GAP_US      = 30,
  parameter int PROG_US     = 20
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          inhibit,
  input  logic          us_tick,
  input  logic          fail_inject,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] out_addr,
  output logic [DW-1:0] out_data
);
  import pgload_pkg::*;

  localparam int OW = $clog2(PAGE_WORDS);
  localparam int PW = AW - OW;
  localparam int CW = $clog2(pg_max(pg_max(LOAD_END_US, PROG_US), GAP_US) + 2);
  localparam logic [CW-1:0] END_C  = CW'(LOAD_END_US);
  localparam logic [CW-1:0] GAP_C  = CW'(GAP_US);
  localparam logic [CW-1:0] PROG_C = CW'(PROG_US);
  localparam logic [OW-1:0] LAST_IDX = OW'(PAGE_WORDS - 1);

  pg_state_e       state, nstate;
  logic [PW-1:0]   page_q;
  logic            any_load;
  logic [OW-1:0]   rd_idx;
  logic            done_q, fail_q;
  logic            fin, fin_fail;

  logic            start_acc, arm;
  logic            open_pulse, close_pulse, pending, open_ok;
  logic [AW-1:0]   cap_addr;
  logic            mismatch, late, idle_done;
  logic [CW-1:0]   idle_cnt, prog_cnt;
  logic [DW-1:0]   rd_data;

  assign arm       = (state == ST_LOAD);
  assign start_acc = (state == ST_IDLE) && start && !inhibit;
  assign idle_done = arm && !pending && (idle_cnt >= END_C);
  assign mismatch  = open_pulse && any_load && (addr[AW-1:OW] != page_q);
  assign late      = open_pulse && any_load && !mismatch && (idle_cnt > GAP_C);
  assign open_ok   = open_pulse && !mismatch && !late && !idle_done;

  pgload_edge #(.AW(AW)) u_edge (
    .clk, .rst_n, .arm, .ce_n, .oe_n, .addr,
    .accept(open_ok), .open_pulse, .close_pulse, .pending, .cap_addr
  );

  pgload_timer #(.CW(CW)) u_idle (
    .clk, .rst_n,
    .clr (start_acc || close_pulse),
    .en  (arm && !pending),
    .tick(us_tick),
    .cnt (idle_cnt)
  );

  pgload_timer #(.CW(CW)) u_prog (
    .clk, .rst_n,
    .clr (state != ST_PROG),
    .en  (state == ST_PROG),
    .tick(us_tick),
    .cnt (prog_cnt)
  );

  pgload_buf #(.WORDS(PAGE_WORDS), .DW(DW)) u_buf (
    .clk, .rst_n,
    .clr  (start_acc),
    .we   (close_pulse),
    .waddr(cap_addr[OW-1:0]),
    .wdata(data),
    .raddr(rd_idx),
    .rdata(rd_data)
  );

  always_comb begin
    nstate   = state;
    fin      = 1'b0;
    fin_fail = 1'b0;
    case (state)
      ST_IDLE: if (start_acc) nstate = ST_LOAD;
      ST_LOAD: begin
        if (mismatch) begin
          nstate = ST_IDLE; fin = 1'b1; fin_fail = 1'b1;
        end else if (late || idle_done) begin
          nstate = ST_PROG;
        end
      end
      ST_PROG: begin
        if (prog_cnt >= PROG_C) begin
          if (fail_inject) begin
            nstate = ST_IDLE; fin = 1'b1; fin_fail = 1'b1;
          end else begin
            nstate = ST_DRAIN;
          end
        end
      end
      ST_DRAIN: begin
        if (out_ready && rd_idx == LAST_IDX) begin
          nstate = ST_IDLE; fin = 1'b1;
        end
      end
      default: nstate = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      page_q   <= '0;
      any_load <= 1'b0;
      rd_idx   <= '0;
      done_q   <= 1'b0;
      fail_q   <= 1'b0;
    end else begin
      state  <= nstate;
      done_q <= fin;
      fail_q <= fin_fail;
      if (start_acc) begin
        page_q   <= '0;
        any_load <= 1'b0;
      end else if (open_ok) begin
        page_q   <= addr[AW-1:OW];
        any_load <= 1'b1;
      end
      if (state != ST_DRAIN)  rd_idx <= '0;
      else if (out_ready)     rd_idx <= rd_idx + 1'b1;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign done      = done_q;
  assign fail      = fail_q;
  assign out_valid = (state == ST_DRAIN);
  assign out_addr  = {page_q, rd_idx};
  assign out_data  = rd_data;

  p_inhibit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && inhibit) |=> !busy);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !inhibit) |=> busy);
  p_fail_has_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(out_data)));
  p_valid_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> busy);
  p_idle_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD) |-> (idle_cnt <= END_C));
  p_busy_start_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (busy || done));
endmodule

// File: tb/sim_pgload_seq.sv
module sim_pgload_seq;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0, inhibit = 1'b0, us_tick = 1'b0, fail_inject = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, out_ready = 1'b0;
  logic [19:0] addr = '0;
  logic [15:0] data = '0;
  logic busy, done, fail, out_valid;
  logic [19:0] out_addr;
  logic [15:0] out_data;

  pgload_seq u0 (.clk, .rst_n, .start, .inhibit, .us_tick, .fail_inject, .ce_n, .oe_n,
                 .addr, .data, .busy, .done, .fail, .out_valid, .out_ready, .out_addr, .out_data);

  int n_chk = 0, n_fail = 0;
  int tick_count = 0, div = 0;
  int t_rise = 0, t_fall = 0;
  logic [15:0] exp_mem [64];

  always @(negedge clk) begin
    div = (div == 4) ? 0 : div + 1;
    us_tick = (div == 0);
    if (us_tick) tick_count++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] mk_addr(input logic [13:0] pg, input int off);
    return {pg, off[5:0]};
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 64; i++) exp_mem[i] = 16'hFFFF;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic load_word(input logic [19:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; oe_n = 1'b1; ce_n = 1'b0; t_fall = tick_count;
    @(negedge clk);
    @(negedge clk); data = d; ce_n = 1'b1; t_rise = tick_count;
    @(negedge clk);
  endtask

  task automatic gap_ticks(input int n);
    int t0;
    t0 = tick_count;
    while (tick_count < t0 + n) @(negedge clk);
  endtask

  task automatic wait_valid(input string req, output int at_tick);
    int guard;
    guard = 0;
    while (!out_valid && guard < 4000) begin
      @(negedge clk); guard++;
      if (!out_valid && !busy) chk(1'b0, "R10", "busy during interval", busy, 1);
    end
    chk(out_valid, req, "out_valid arrival", out_valid, 1);
    at_tick = tick_count;
  endtask

  task automatic drain_check(input string req, input logic [13:0] pg, input bit rnd);
    int got, guard;
    logic pv, pr;
    logic [15:0] pd;
    logic [19:0] pa;
    got = 0; guard = 0; pv = 0; pr = 0; pd = 0; pa = 0;
    while (got < 64 && guard < 5000) begin
      @(negedge clk); guard++;
      if (pv && !pr)
        chk(out_valid && out_data == pd && out_addr == pa, "R11", "hold under back-pressure",
            {out_addr[15:0], out_data}, {pa[15:0], pd});
      out_ready = rnd ? 1'($urandom % 2) : 1'b1;
      if (out_valid && out_ready) begin
        chk(out_addr == mk_addr(pg, got), "R4", "stream address", out_addr, mk_addr(pg, got));
        chk(out_data == exp_mem[got], req, "stream data", out_data, exp_mem[got]);
        got++;
      end
      pv = out_valid; pr = out_ready; pd = out_data; pa = out_addr;
    end
    chk(got == 64, "R11", "word count", got, 64);
    @(negedge clk); out_ready = 1'b0;
    chk(done && !fail && !busy, "R10", "done/fail/busy at end", {done, fail, busy}, 3'b100);
    @(negedge clk);
    chk(!done, "R10", "done is one pulse", done, 0);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int tv;
    bit saw;
    logic [13:0] pg;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !out_valid, "R1", "reset outputs",
        {busy, done, fail, out_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !out_valid, "R1", "after reset", {busy, out_valid}, 0);

    // R2: inhibited start
    inhibit = 1'b1; pulse_start();
    chk(!busy, "R2", "inhibited start", busy, 0);
    @(negedge clk);
    chk(!busy, "R2", "inhibited start later", busy, 0);
    inhibit = 1'b0;

    // Directed page: any order, overwrite, oe-low pulse, start while busy
    pg = 14'h1A5; model_clear();
    pulse_start();
    chk(busy, "R2", "start accepted", busy, 1);
    load_word(mk_addr(pg, 5), 16'h1111);
    load_word(mk_addr(pg, 0), 16'h2222);
    load_word(mk_addr(pg, 63), 16'h3333);
    pulse_start();   // R13: ignored while busy
    @(negedge clk); addr = mk_addr(pg, 9); oe_n = 1'b0; ce_n = 1'b0;  // R3: not a load
    @(negedge clk); data = 16'h9999; ce_n = 1'b1;
    @(negedge clk); oe_n = 1'b1;
    load_word(mk_addr(pg, 5), 16'h4444);  // R5 overwrite
    exp_mem[0] = 16'h2222; exp_mem[5] = 16'h4444; exp_mem[63] = 16'h3333;
    wait_valid("R8", tv);
    chk((tv - t_rise) == 120 || (tv - t_rise) == 121, "R8", "ticks to stream", tv - t_rise, 120);
    drain_check("R3", pg, 1'b1);

    // R6/R8: nothing loaded
    model_clear();
    pulse_start(); t_rise = tick_count;
    wait_valid("R8", tv);
    chk((tv - t_rise) >= 119 && (tv - t_rise) <= 121, "R8", "ticks with no load", tv - t_rise, 120);
    drain_check("R6", 14'h0, 1'b0);

    // R7: page mismatch
    pg = 14'h0C3;
    pulse_start();
    load_word(mk_addr(pg, 3), 16'hAAAA);
    @(negedge clk); addr = mk_addr(pg ^ 14'h1, 4); ce_n = 1'b0;
    @(negedge clk);
    chk(done && fail && !busy, "R7", "mismatch end", {done, fail, busy}, 3'b110);
    ce_n = 1'b1;
    @(negedge clk);
    chk(!done && !fail, "R7", "mismatch pulse width", {done, fail}, 0);
    saw = 0;
    repeat (50) begin @(negedge clk); if (out_valid) saw = 1; end
    chk(!saw, "R7", "no stream after mismatch", saw, 0);

    // R9: late load closes loading and is dropped
    pg = 14'h2F0; model_clear();
    pulse_start();
    load_word(mk_addr(pg, 1), 16'h0101);
    gap_ticks(40);
    load_word(mk_addr(pg, 2), 16'h0202);
    exp_mem[1] = 16'h0101;
    wait_valid("R9", tv);
    chk((tv - t_fall) == 20 || (tv - t_fall) == 21, "R9", "ticks after late load", tv - t_fall, 20);
    drain_check("R9", pg, 1'b1);

    // R12: injected failure
    fail_inject = 1'b1;
    pulse_start();
    load_word(mk_addr(14'h10, 7), 16'h7777);
    saw = 0; tv = 0;
    while (!done && tv < 3000) begin @(negedge clk); tv++; if (out_valid) saw = 1; end
    chk(done && fail, "R12", "fail pulse", {done, fail}, 2'b11);
    chk(!saw, "R12", "no stream on failure", saw, 0);
    fail_inject = 1'b0;
    @(negedge clk);

    // Random pages
    for (int it = 0; it < 4; it++) begin
      int nl;
      pg = 14'($urandom); model_clear();
      nl = 1 + ($urandom % 20);
      pulse_start();
      for (int k = 0; k < nl; k++) begin
        int off;
        logic [15:0] d;
        off = $urandom % 64; d = 16'($urandom);
        load_word(mk_addr(pg, off), d);
        exp_mem[off] = d;
        gap_ticks($urandom % 10);
      end
      wait_valid("R8", tv);
      chk((tv - t_rise) >= 120 && (tv - t_rise) <= 121, "R8", "random ticks", tv - t_rise, 120);
      drain_check("R5", pg, 1'b1);
    end
    report();
  end
endmodule